// File: doc/BRIEF.md
# Framed Serial Result Transmitter

This block sends each 12-bit conversion result out as a 16-bit serial frame on three open-drain lines: a serial clock, an active-low frame strobe and a data line. A single-cycle start event, the same event that launches a conversion, latches the result and arms the transmitter. The frame opens with four zero bits and then carries the result most significant bit first. Each line is modelled as a pull-down enable: a 1 on the port means the line is driven low, and a 0 means it is released to the external pull-up.

The serial clock is the converter clock divided by two. A mode input selects whether it toggles all the time, for receivers that expect a clock that never stops, or only while a frame is on the wire. In the gated case the clock rests released (high) between frames, so several transmitters can share one clock and data pair. Data moves on the rising edge of the serial clock and is meant to be sampled on the falling edge while the strobe is low. A start that arrives while a frame is pending or in flight is dropped, and a busy output shows when this is the case.

Top module: `sertx_frame_tx`

## Requirements
- R1: A frame carries 16 bits, one per serial-clock falling edge with the strobe low: four 0 bits first, then the result latched in the cycle the start was accepted, bit 11 first and bit 0 last. Later changes on the result input do not alter a frame already accepted.
- R2: While the strobe is low, the data line changes only on a rising edge of the serial clock and holds its level across every falling edge.
- R3: The strobe goes low at most three converter-clock rising edges after the start is sampled, counting the edge that samples it.
- R4: The first serial-clock falling edge after the strobe goes low carries the first leading zero, and the strobe returns high on the converter-clock edge that follows the 16th falling edge.
- R5: Whenever the serial clock toggles, each high and each low phase lasts exactly one converter-clock cycle.
- R6: With `sclk_free` at 0, the serial clock is released (high) in every cycle that follows an idle cycle, and toggles only while a frame is pending or in flight.
- R7: With `sclk_free` at 1, the serial clock toggles on every converter-clock edge, whether a frame is pending or not.
- R8: Each serial output is a pull-down enable (1 = line driven low, 0 = line released). The data line is released whenever the strobe is high, and a 0 bit is sent by pulling it low.
- R9: `busy` is 1 from the edge that accepts a start until the strobe returns high. A start sampled while `busy` is 1 is ignored and does not change the frame in flight.
- R10: While reset is held, all three lines are released and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| conv_start | input | 1 | Start event, sampled on the rising edge of `clk` |
| conv_result | input | 12 | Conversion result, latched when a start is accepted |
| sclk_free | input | 1 | 1 = serial clock runs continuously, 0 = serial clock gated to frames |
| busy | output | 1 | A frame is pending or in flight |
| sclk_pull | output | 1 | Pull-down enable of the serial clock line |
| frame_pull | output | 1 | Pull-down enable of the frame strobe (line low = frame active) |
| sdata_pull | output | 1 | Pull-down enable of the serial data line |

## Verification
The bench goes after the alignment between the strobe, the first falling edge and the leading zeros in both clock modes. It also varies the phase of a free-running clock at the moment of the start, because a design that opened the frame on the wrong edge would drop or duplicate the first zero, or would lower the strobe too late. Starts fired into a frame already in flight, with a different result on the input, would corrupt or restart the frame if they were not ignored. Starts issued the moment `busy` drops would lose a frame if the end of one frame and the acceptance of the next overlapped. A gated clock that leaked a pulse between frames, or data that moved on a falling edge, shows up as a cycle mismatch against the behavioural model and in the decoded frames.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARM   = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;

endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sertx_clkdiv.sv
module sertx_clkdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_q,
  output logic sclk_up
);

  logic sclk_d;

  // Toggle each cycle while running, otherwise park released (high).
  always_comb begin
    if (run) begin
      sclk_d = ~sclk_q;
    end else begin
      sclk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
    end else begin
      sclk_q <= sclk_d;
    end
  end

  // The coming edge leaves the serial clock high: launch point for data.
  assign sclk_up = sclk_d;

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      sclk_up,
  input  logic      last,
  output tx_state_e state_q,
  output logic      load,
  output logic      shift
);

  tx_state_e state_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (start) begin
          state_d = TX_ARM;
          load    = 1'b1;
        end
      end
      TX_ARM: begin
        if (sclk_up) begin
          state_d = TX_SHIFT;
        end
      end
      TX_SHIFT: begin
        if (sclk_up) begin
          if (last) begin
            state_d = TX_IDLE;
          end else begin
            shift = 1'b1;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int RES_W  = 12,
  parameter int LEAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [RES_W-1:0] result,
  output logic             msb,
  output logic             last
);

  localparam int FRAME_W = RES_W + LEAD_W;
  localparam int CNT_W   = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               en;

  generate
    if (LEAD_W > 0) begin : g_lead
      assign frame_w = {{LEAD_W{1'b0}}, result};
    end else begin : g_nolead
      assign frame_w = result;
    end
  endgenerate

  assign en = load | shift;

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (load) begin
      shreg_d = frame_w;
      cnt_d   = '0;
    end else if (shift) begin
      shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (en) begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign msb  = shreg_q[FRAME_W-1];
  assign last = (cnt_q == LAST_IDX);

endmodule

// File: rtl/sertx_frame_tx.sv
module sertx_frame_tx
  import sertx_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int LEAD_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic [RES_W-1:0] conv_result,
  input  logic             sclk_free,
  output logic             busy,
  output logic             sclk_pull,
  output logic             frame_pull,
  output logic             sdata_pull
);

  logic      rst_int_n;
  logic      run;
  logic      sclk_q;
  logic      sclk_up;
  logic      load;
  logic      shift;
  logic      msb;
  logic      last;
  logic      in_frame;
  tx_state_e state_q;

  sertx_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_sync_n(rst_int_n)
  );

  assign in_frame = (state_q == TX_SHIFT);
  assign run      = sclk_free | in_frame;

  sertx_clkdiv u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (run),
    .sclk_q (sclk_q),
    .sclk_up(sclk_up)
  );

  sertx_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (conv_start),
    .sclk_up(sclk_up),
    .last   (last),
    .state_q(state_q),
    .load   (load),
    .shift  (shift)
  );

  sertx_shifter #(
    .RES_W (RES_W),
    .LEAD_W(LEAD_W)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (load),
    .shift (shift),
    .result(conv_result),
    .msb   (msb),
    .last  (last)
  );

  assign busy       = (state_q != TX_IDLE);
  assign sclk_pull  = ~sclk_q;
  assign frame_pull = in_frame;
  assign sdata_pull = in_frame & ~msb;

endmodule

// File: rtl/sertx_frame_tx_chk.sv
module sertx_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic sclk_free,
  input logic busy,
  input logic sclk_pull,
  input logic frame_pull,
  input logic sdata_pull
);

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !busy) |=> busy); // R9

  AST_FRAME_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pull |-> busy); // R9

  AST_FREE_SCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_free |=> (sclk_pull != $past(sclk_pull))); // R7

  AST_GATED_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_free && !busy) |=> !sclk_pull); // R6

  AST_DATA_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_pull |-> frame_pull); // R8

  AST_DATA_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk_pull) && $past(frame_pull)) |-> $stable(sdata_pull)); // R2

endmodule

bind sertx_frame_tx sertx_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .conv_start(conv_start),
  .sclk_free (sclk_free),
  .busy      (busy),
  .sclk_pull (sclk_pull),
  .frame_pull(frame_pull),
  .sdata_pull(sdata_pull)
);

// File: tb/sertx_frame_tx_tb_top.sv
`timescale 1ns/1ps
module sertx_frame_tx_tb_top;

  localparam int RES_W = 12;
  localparam int FW    = 16;

  logic             clk;
  logic             rst_n;
  logic             conv_start;
  logic [RES_W-1:0] conv_result;
  logic             sclk_free;
  logic             busy, sclk_pull, frame_pull, sdata_pull;

  sertx_frame_tx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .conv_result(conv_result),
    .sclk_free  (sclk_free),
    .busy       (busy),
    .sclk_pull  (sclk_pull),
    .frame_pull (frame_pull),
    .sdata_pull (sdata_pull)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  longint t0 = 0;
  bit     finished = 0;

  // behavioural reference: 0 idle, 1 waiting for launch, 2 sending
  int   m_state = 0;
  bit   m_sclk = 1'b1;
  bit   m_q[$];
  int   rel = 0;
  bit   m_run, m_nxt;

  logic [RES_W-1:0] exp_res[$];
  logic [FW-1:0]    col;
  int               ncol = 0;
  bit p_valid = 0, p_sclk = 1, p_fl = 1, p_dl = 1, p_busy = 0, p_free = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || rel < 2) begin
      if (!rst_n) rel = 0; else rel++;
      m_state = 0;
      m_sclk  = 1'b1;
      m_q.delete();
    end else begin
      m_run = sclk_free || (m_state == 2);
      m_nxt = m_run ? !m_sclk : 1'b1;
      case (m_state)
        0: if (conv_start) begin
             m_q.delete();
             for (int i = FW - 1; i >= 0; i--)
               m_q.push_back(i < RES_W ? conv_result[i] : 1'b0);
             m_state = 1;
           end
        1: if (m_nxt) m_state = 2;
        default: if (m_nxt) begin
             void'(m_q.pop_front());
             if (m_q.size() == 0) m_state = 0;
           end
      endcase
      m_sclk = m_nxt;
    end
  end

  always @(negedge clk) begin
    bit sl, fl, dl, e_sdat;
    longint lat;
    sl = !sclk_pull; fl = !frame_pull; dl = !sdata_pull;
    e_sdat = (m_state == 2) && (m_q.size() > 0) && !m_q[0];
    chk(sclk_pull == !m_sclk, "R5", "sclk_pull vs model", sclk_pull, !m_sclk);
    chk(frame_pull == (m_state == 2), "R4", "frame_pull vs model", frame_pull, m_state == 2);
    chk(sdata_pull == e_sdat, "R1", "sdata_pull vs model", sdata_pull, e_sdat);
    chk(busy == (m_state != 0), "R9", "busy vs model", busy, m_state != 0);
    chk(!(sdata_pull && !frame_pull), "R8", "data pulled outside frame", sdata_pull, 0);
    if (p_valid) begin
      if (p_sclk && !sl && !fl) begin
        col = {col[FW-2:0], dl};
        ncol++;
      end
      if (p_fl && !fl) begin
        lat = cyc - t0;
        chk(lat <= 3, "R3", "strobe latency", lat, 3);
      end
      if (!p_fl && fl) begin
        chk(ncol == FW, "R4", "bits per frame", ncol, FW);
        if (exp_res.size() > 0) begin
          logic [RES_W-1:0] r;
          r = exp_res.pop_front();
          chk(col == {4'b0, r}, "R1", "frame content", col, {4'b0, r});
        end else begin
          chk(0, "R1", "unexpected frame", col, 0);
        end
        ncol = 0;
      end
      if (!fl && !p_fl && dl != p_dl)
        chk(!p_sclk && sl, "R2", "data moved off rising edge", sl, 1);
      if (!sclk_free && !p_free && !p_busy)
        chk(sl, "R6", "gated clock idle level", sl, 1);
      if (sclk_free && p_free)
        chk(sl != p_sclk, "R7", "free clock toggle", sl, !p_sclk);
    end
    p_sclk = sl; p_fl = fl; p_dl = dl; p_busy = busy; p_free = sclk_free;
    p_valid = (rel == 2);
  end

  always @(posedge clk) begin
    if (cyc > 60000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 60000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send(input logic [RES_W-1:0] r, input int gap);
    while (busy) @(negedge clk);
    repeat (gap) @(negedge clk);
    conv_result = r;
    conv_start  = 1'b1;
    exp_res.push_back(r);
    t0 = cyc;
    @(negedge clk);
    conv_start  = 1'b0;
    conv_result = ~r;  // R1: later input changes must not leak in
  endtask

  task automatic poke_busy(input logic [RES_W-1:0] r, input int delay);
    while (!busy) @(negedge clk);
    repeat (delay) @(negedge clk);
    conv_result = r;
    conv_start  = 1'b1;  // R9: should be ignored
    @(negedge clk);
    conv_start  = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    conv_start = 1'b0;
    conv_result = '0;
    sclk_free = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!sclk_pull && !frame_pull && !sdata_pull, "R10", "lines released in reset",
        {sclk_pull, frame_pull, sdata_pull}, 0);
    chk(!busy, "R10", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // gated mode frames
    send(12'hA5C, 0);
    send(12'hFFF, 2);
    poke_busy(12'h123, 0);
    send(12'h000, 1);
    poke_busy(12'h3C3, 10);
    send(12'h801, 0);
    send(12'h7FE, 0);
    while (busy) @(negedge clk);
    repeat (8) @(negedge clk);

    // continuous mode, different phases at start
    sclk_free = 1'b1;
    repeat (5) @(negedge clk);
    send(12'h5A5, 0);
    send(12'h001, 1);
    poke_busy(12'hEEE, 3);
    send(12'hC00, 2);
    send(12'h3FF, 3);
    send(12'h9B6, 0);
    while (busy) @(negedge clk);
    repeat (7) @(negedge clk);

    // back to gated, a last pair of frames
    sclk_free = 1'b0;
    repeat (4) @(negedge clk);
    send(12'h4D2, 0);
    send(12'hB2B, 0);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);

    chk(exp_res.size() == 0, "R1", "frames left unsent", exp_res.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule